// File: doc/BRIEF.md
# Multi-Channel ADC Sequencer and Result Holder

This block sits between firmware and a sampling converter that serves twelve input channels, numbered 0 to 7 and 13 to 16. Firmware uses a byte-wide register bus to turn on one or more channels and to set the global run bit. The block then chooses a channel and waits for a settling interval plus a conversion interval whose length is set by a divider. After that it asks the converter for a sample over a request/acknowledge port. It stores the 10-bit answer in that channel's result bytes and raises the channel's ready flag.

Firmware reads the result and retires the ready flag by writing a one to it, either through the status registers or through the channel's control byte. An optional hold mode keeps a stored result unchanged until its flag is retired. A level interrupt stays high while any enabled channel with its interrupt allowed has a pending flag.

The block has 12 channel slots. Slot k holds channel k for k < 8 and channel k+5 for k >= 8. Slots 0 to 3 use a channel-select control encoding. Slots 4 to 11 use an enable-bit encoding.

Top module: `adc_chan_top`

## Requirements
- R1: After reset, every register reads 0. The one exception is the control byte of slots 0 to 3, which reads 0x1F. Neither convReq nor irq is asserted.
- R2: The global register at 0x00 holds the run bit in bit 0 and the hold bit in bit 1. While the run bit is 0, no request is raised. Clearing the run bit abandons any pending wait or request.
- R3: In slots 0 to 3, the control byte holds a select field in bits [4:0]. The slot is enabled only when the field equals its own channel number. Writing 0xA0+ch enables the slot with its interrupt, and writing 0x9F disables it. In every slot, bit 5 is the interrupt allow bit. Bit 7 reads back the ready flag, and writing 1 to bit 7 retires the flag.
- R4: In slots 4 to 11, bit 4 of the control byte is the enable bit. Writing 0xB0 enables the slot with its interrupt, and writing 0x80 disables it. A read returns {ready, 0, allow, enable, 0000}.
- R5: Register 0x02 shows the ready flags of channels 0 to 7 in bits 0 to 7. Register 0x03 shows channels 13 to 16 in bits 0 to 3. Writing a 1 to a bit clears that flag. Writing a 0 leaves it unchanged.
- R6: The control byte of slot k is at 0x10+4k. The result upper byte at +1 holds result bits [9:8] in bits [1:0]. The lower byte at +2 holds bits [7:0].
- R7: While the hold bit is 1, a new sample for a slot whose flag is already set is dropped and the stored result stays the same. While the hold bit is 0, each sample overwrites the result.
- R8: irq is high exactly while some slot is enabled, has its allow bit set and has its ready flag set.
- R9: Register 0x01 holds a 6-bit divider d. When the run bit is written and at least one slot is already enabled, convReq rises SAMPLE_CYC + STEP_CYC*(d+1) + 1 clock edges after the write edge.
- R10: The enabled slot with the lowest index is served. After each acknowledge, the choice is made again, so a slot that stays enabled is converted over and over. Disabling the chosen slot abandons its wait or request.
- R11: Suppose a sample is stored on the same edge as a write that retires the same flag. The flag ends up set.
- R12: While convReq is high, convCh gives the channel number (0 to 7 or 13 to 16) of the chosen slot. The sample on convData is taken on the edge where convAck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWr | input | 1 | Write strobe for one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| convReq | output | 1 | Sample request to the converter |
| convCh | output | 5 | Channel number of the request |
| convAck | input | 1 | Converter acknowledge, which carries convData |
| convData | input | 10 | Converter sample |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the edge where a sample is stored and the same flag is retired by a bus write. Both events must land in one clock cycle, and the moment of the store depends on the converter's acknowledge. To reach it, the bench's converter model drives the status-register write on the same falling edge where it raises convAck. The store and the clear then meet at the next rising edge. The bench also holds back acknowledges until the driver grants them. This makes every stored sample and every served channel predictable, even while a slot converts over and over.

// File: rtl/adc_chan_pkg.sv
package adc_chan_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int NUM_SLOT     = 12;
  localparam int SLOT_W       = 4;
  localparam int BANK0_CNT    = 8;
  localparam int SEL_SLOTS    = 4;
  localparam int HIGH_CH_BASE = 13;
  localparam int RES_W        = 10;
  localparam int CH_W         = 5;

  localparam logic [7:0] ADDR_CFG   = 8'h00;
  localparam logic [7:0] ADDR_DIV   = 8'h01;
  localparam logic [7:0] ADDR_STAT0 = 8'h02;
  localparam logic [7:0] ADDR_STAT1 = 8'h03;
  localparam logic [7:0] SLOT_BASE  = 8'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_REQ} convState_t;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic              latch;
    logic [SLOT_W-1:0] slot;
    logic [RES_W-1:0]  data;
  } convStrobe_t;

  function automatic logic [CH_W-1:0] slotToCh(input logic [SLOT_W-1:0] s);
    if (int'(s) < BANK0_CNT) return CH_W'(int'(s));
    return CH_W'(int'(s) + HIGH_CH_BASE - BANK0_CNT);
  endfunction
endpackage

// File: rtl/adc_chan_regs.sv
module adc_chan_regs
  import adc_chan_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [7:0]                busAddr,
  input  logic                      busWr,
  input  logic [7:0]                busWdata,
  output logic [7:0]                busRdata,
  input  convStrobe_t               strobe,
  output logic                      modEn,
  output logic                      keepEn,
  output logic [DIV_W-1:0]          divVal,
  output logic [NUM_SLOT-1:0]       enMask,
  output logic [NUM_SLOT-1:0]       validVec,
  output logic [NUM_SLOT*RES_W-1:0] resFlat,
  output logic                      irq
);
  timeunit 1ns; timeprecision 1ps;

  localparam int HI_CNT = NUM_SLOT - BANK0_CNT;

  logic [NUM_SLOT-1:0] ienVec;
  logic [7:0]          ctlRd [NUM_SLOT];
  logic [RES_W-1:0]    resArr [NUM_SLOT];

  // global registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modEn  <= 1'b0;
      keepEn <= 1'b0;
      divVal <= '0;
    end else if (busWr) begin
      if (busAddr == ADDR_CFG) begin
        modEn  <= busWdata[0];
        keepEn <= busWdata[1];
      end
      if (busAddr == ADDR_DIV) divVal <= busWdata[DIV_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    localparam logic [7:0] CTL_ADDR = 8'(int'(SLOT_BASE) + 4*k);
    logic ctlWr, statClr, clrHit, setHit;
    logic validReg, ienReg;
    logic [RES_W-1:0] resReg;

    assign ctlWr = busWr && (busAddr == CTL_ADDR);
    if (k < BANK0_CNT) begin : g_st0
      assign statClr = busWr && (busAddr == ADDR_STAT0) && busWdata[k];
    end else begin : g_st1
      assign statClr = busWr && (busAddr == ADDR_STAT1) && busWdata[k-BANK0_CNT];
    end
    assign clrHit = (ctlWr && busWdata[7]) || statClr;
    assign setHit = strobe.latch && (strobe.slot == SLOT_W'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validReg <= 1'b0;
        ienReg   <= 1'b0;
        resReg   <= '0;
      end else begin
        if (setHit)      validReg <= 1'b1;   // set beats clear
        else if (clrHit) validReg <= 1'b0;
        if (ctlWr) ienReg <= busWdata[5];
        if (setHit && !(keepEn && validReg)) resReg <= strobe.data;
      end
    end

    if (k < SEL_SLOTS) begin : g_sel
      logic [4:0] selReg;
      always_ff @(posedge clk) begin
        if (!rstN)      selReg <= 5'h1F;
        else if (ctlWr) selReg <= busWdata[4:0];
      end
      assign enMask[k] = (selReg == 5'(k));
      assign ctlRd[k]  = {validReg, 1'b0, ienReg, selReg};
    end else begin : g_bit
      logic enReg;
      always_ff @(posedge clk) begin
        if (!rstN)      enReg <= 1'b0;
        else if (ctlWr) enReg <= busWdata[4];
      end
      assign enMask[k] = enReg;
      assign ctlRd[k]  = {validReg, 1'b0, ienReg, enReg, 4'b0000};
    end

    assign validVec[k] = validReg;
    assign ienVec[k]   = ienReg;
    assign resArr[k]   = resReg;
    assign resFlat[k*RES_W +: RES_W] = resReg;
  end

  assign irq = |(validVec & ienVec & enMask);

  always_comb begin
    busRdata = 8'h00;
    unique case (busAddr)
      ADDR_CFG:   busRdata = {6'b0, keepEn, modEn};
      ADDR_DIV:   busRdata = {{(8-DIV_W){1'b0}}, divVal};
      ADDR_STAT0: busRdata = validVec[BANK0_CNT-1:0];
      ADDR_STAT1: busRdata = {{(8-HI_CNT){1'b0}}, validVec[NUM_SLOT-1:BANK0_CNT]};
      default: begin
        for (int k = 0; k < NUM_SLOT; k++) begin
          if (busAddr == 8'(int'(SLOT_BASE) + 4*k))     busRdata = ctlRd[k];
          if (busAddr == 8'(int'(SLOT_BASE) + 4*k + 1)) busRdata = {6'b0, resArr[k][RES_W-1:8]};
          if (busAddr == 8'(int'(SLOT_BASE) + 4*k + 2)) busRdata = resArr[k][7:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/adc_chan_ctrl.sv
module adc_chan_ctrl
  import adc_chan_pkg::*;
#(
  parameter int SAMPLE_CYC = 6,
  parameter int STEP_CYC   = 4,
  parameter int DIV_W      = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modEn,
  input  logic [NUM_SLOT-1:0] enMask,
  input  logic [DIV_W-1:0]    divVal,
  output logic                convReq,
  output logic [CH_W-1:0]     convCh,
  input  logic                convAck,
  input  logic [RES_W-1:0]    convData,
  output convStrobe_t         strobe
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CNT_W = $clog2(SAMPLE_CYC + STEP_CYC * (2 ** DIV_W) + 1);

  convState_t        state;
  logic [SLOT_W-1:0] slotReg, pick;
  logic [CNT_W-1:0]  cnt, waitLen;
  logic              anyEn, slotLive;

  always_comb begin
    pick = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) if (enMask[i]) pick = SLOT_W'(i);
  end

  assign anyEn    = |enMask;
  assign slotLive = modEn && enMask[slotReg];
  assign waitLen  = CNT_W'(SAMPLE_CYC + STEP_CYC - 1) + CNT_W'(STEP_CYC) * CNT_W'(divVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotReg <= '0;
      cnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (modEn && anyEn) begin
          slotReg <= pick;
          cnt     <= waitLen;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!slotLive)     state <= ST_IDLE;
          else if (cnt == 0) state <= ST_REQ;
          else               cnt   <= cnt - 1'b1;
        end
        ST_REQ: if (!slotLive || convAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convReq      = (state == ST_REQ);
  assign convCh       = slotToCh(slotReg);
  assign strobe.latch = convReq && convAck && slotLive;
  assign strobe.slot  = slotReg;
  assign strobe.data  = convData;
endmodule

// File: rtl/adc_chan_top.sv
module adc_chan_top
  import adc_chan_pkg::*;
#(
  parameter int SAMPLE_CYC = 6,
  parameter int STEP_CYC   = 4,
  parameter int DIV_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWr,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  output logic             convReq,
  output logic [CH_W-1:0]  convCh,
  input  logic             convAck,
  input  logic [RES_W-1:0] convData,
  output logic             irq
);
  timeunit 1ns; timeprecision 1ps;

  convStrobe_t               strobe;
  logic                      modEn, keepEn;
  logic [DIV_W-1:0]          divVal;
  logic [NUM_SLOT-1:0]       enMask, validVec;
  logic [NUM_SLOT*RES_W-1:0] resFlat;

  adc_chan_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe),
    .modEn(modEn), .keepEn(keepEn), .divVal(divVal), .enMask(enMask),
    .validVec(validVec), .resFlat(resFlat), .irq(irq)
  );

  adc_chan_ctrl #(.SAMPLE_CYC(SAMPLE_CYC), .STEP_CYC(STEP_CYC), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modEn(modEn), .enMask(enMask), .divVal(divVal),
    .convReq(convReq), .convCh(convCh), .convAck(convAck),
    .convData(convData), .strobe(strobe)
  );
endmodule

// File: rtl/adc_chan_chk.sv
module adc_chan_chk
  import adc_chan_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      convReq,
  input logic                      convAck,
  input logic [CH_W-1:0]           convCh,
  input logic                      irq,
  input logic                      modEn,
  input logic                      keepEn,
  input logic [NUM_SLOT-1:0]       validVec,
  input logic [NUM_SLOT*RES_W-1:0] resFlat,
  input convStrobe_t               strobe
);
  timeunit 1ns; timeprecision 1ps;

  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> !convReq); // R2

  AST_CH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> (convCh < 5'd8 || (convCh >= 5'd13 && convCh <= 5'd16))); // R12

  AST_LATCH_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |-> (convReq && convAck)); // R12

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (validVec != '0)); // R8

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.latch && strobe.slot == SLOT_W'(k)) |=> validVec[k]); // R11

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      (keepEn && validVec[k]) |=> $stable(resFlat[k*RES_W +: RES_W])); // R7
  end
endmodule

bind adc_chan_top adc_chan_chk chk_i (
  .clk(clk), .rstN(rstN), .convReq(convReq), .convAck(convAck),
  .convCh(convCh), .irq(irq), .modEn(modEn), .keepEn(keepEn),
  .validVec(validVec), .resFlat(resFlat), .strobe(strobe)
);

// File: tb/adc_chan_top_tb_top.sv
module adc_chan_top_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int SAMPLE_CYC = 6;
  localparam int STEP_CYC   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       convReq;
  logic [4:0] convCh;
  logic       convAck = 1'b0;
  logic [9:0] convData = 10'h0;
  logic       irq;

  int nChecks = 0;
  int nErrs   = 0;
  int expCh[$];
  int ackBudget = 0;
  logic [9:0] nextVal = 10'h0;
  bit collideArm = 1'b0;
  bit collideClr = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_chan_top #(.SAMPLE_CYC(SAMPLE_CYC), .STEP_CYC(STEP_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .convReq(convReq),
    .convCh(convCh), .convAck(convAck), .convData(convData), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output int d);
    @(negedge clk);
    busAddr = a;
    #1 d = int'(busRdata);
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input int exp);
    int v;
    regRd(a, v);
    chk(tag, v, exp);
  endtask

  // driver: grant one acknowledge and record the channel expected to be served
  task automatic convertOnce(input int ch, input logic [9:0] val);
    nextVal = val;
    expCh.push_back(ch);
    ackBudget++;
    wait (ackBudget == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic measureLatency(input string tag, input int exp);
    int n = 0;
    while (!convReq && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, n, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  endtask

  // converter model and scoreboard monitor
  always @(negedge clk) begin
    convAck = 1'b0;
    if (collideClr) begin
      busWr = 1'b0;
      collideClr = 1'b0;
    end
    if (rstN && convReq && ackBudget > 0) begin
      convAck  = 1'b1;
      convData = nextVal;
      ackBudget--;
      if (expCh.size() == 0) chk("R12 unexpected request", int'(convCh), -1);
      else chk("R10/R12 served channel", int'(convCh), expCh.pop_front());
      if (collideArm) begin
        busAddr = 8'h03; busWdata = 8'h02; busWr = 1'b1;
        collideArm = 1'b0;
        collideClr = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 slot0 ctl", 8'h10, 8'h1F);
    rdChk("R1 slot5 ctl", 8'h24, 8'h00);
    rdChk("R1 cfg", 8'h00, 8'h00);
    rdChk("R1 stat0", 8'h02, 8'h00);
    chk("R1 irq", int'(irq), 0);
    chk("R1 convReq", int'(convReq), 0);

    // R2 run bit off: no request
    regWr(8'h01, 8'h00);
    regWr(8'h24, 8'hB0);
    repeat (40) @(negedge clk);
    chk("R2 no request while stopped", int'(convReq), 0);
    rdChk("R4 slot5 enabled readback", 8'h24, 8'h30);

    // R9 latency with d=0
    regWr(8'h00, 8'h01);
    measureLatency("R9 latency d=0", SAMPLE_CYC + STEP_CYC * 1 + 1);

    convertOnce(5, 10'h2A5);
    rdChk("R5 stat0 flag ch5", 8'h02, 8'h20);
    rdChk("R6 result upper", 8'h25, 8'h02);
    rdChk("R6 result lower", 8'h26, 8'hA5);
    rdChk("R3 ready in bit7", 8'h24, 8'hB0);
    chk("R8 irq raised", int'(irq), 1);

    regWr(8'h02, 8'h20);
    rdChk("R5 w1c stat0", 8'h02, 8'h00);
    chk("R8 irq dropped", int'(irq), 0);

    // R7 overwrite without hold
    convertOnce(5, 10'h111);
    convertOnce(5, 10'h222);
    rdChk("R7 overwrite lower", 8'h26, 8'h22);
    rdChk("R7 overwrite upper", 8'h25, 8'h02);

    // R7 hold mode
    regWr(8'h00, 8'h03);
    convertOnce(5, 10'h0AA);
    rdChk("R7 held lower", 8'h26, 8'h22);
    rdChk("R7 flag still set", 8'h02, 8'h20);
    regWr(8'h24, 8'hB0);
    rdChk("R3 bit7 w1c", 8'h02, 8'h00);
    convertOnce(5, 10'h0AA);
    rdChk("R7 stored after clear lower", 8'h26, 8'hAA);
    rdChk("R7 stored after clear upper", 8'h25, 8'h00);

    // R10 lowest first, repeated
    regWr(8'h00, 8'h00);
    regWr(8'h18, 8'hA2);
    regWr(8'h34, 8'hB0);
    regWr(8'h00, 8'h01);
    convertOnce(2, 10'h301);
    convertOnce(2, 10'h302);
    rdChk("R10 ch2 upper", 8'h19, 8'h03);
    rdChk("R10 ch2 lower", 8'h1A, 8'h02);
    rdChk("R5 stat0 ch2+ch5", 8'h02, 8'h24);
    rdChk("R3 select readback", 8'h18, 8'hA2);
    regWr(8'h18, 8'h9F);
    rdChk("R3 disabled readback", 8'h18, 8'h1F);
    rdChk("R3 disable retires flag", 8'h02, 8'h20);
    convertOnce(5, 10'h3FF);
    rdChk("R6 full scale upper", 8'h25, 8'h03);
    rdChk("R6 full scale lower", 8'h26, 8'hFF);
    regWr(8'h24, 8'h80);
    convertOnce(14, 10'h155);
    rdChk("R5 stat1 ch14 bit1", 8'h03, 8'h02);
    rdChk("R5 stat0 empty", 8'h02, 8'h00);
    rdChk("R6 ch14 upper", 8'h35, 8'h01);
    rdChk("R6 ch14 lower", 8'h36, 8'h55);

    // R8 interrupt gating
    chk("R8 irq ch14", int'(irq), 1);
    regWr(8'h34, 8'h10);
    chk("R8 allow off", int'(irq), 0);
    rdChk("R4 flag kept", 8'h03, 8'h02);
    regWr(8'h34, 8'h20);
    chk("R8 slot disabled", int'(irq), 0);
    regWr(8'h34, 8'h30);
    chk("R8 irq back", int'(irq), 1);

    // R11 store and clear on one edge
    collideArm = 1'b1;
    convertOnce(14, 10'h0F0);
    rdChk("R11 set wins", 8'h03, 8'h02);
    rdChk("R11 result stored", 8'h36, 8'hF0);
    regWr(8'h03, 8'h02);
    rdChk("R5 w1c stat1", 8'h03, 8'h00);

    // R9 latency with d=3
    regWr(8'h00, 8'h00);
    regWr(8'h01, 8'h03);
    rdChk("R9 divider readback", 8'h01, 8'h03);
    regWr(8'h00, 8'h01);
    measureLatency("R9 latency d=3", SAMPLE_CYC + STEP_CYC * 4 + 1);

    chk("R12 all expected served", expCh.size(), 0);
    finishRun();
  end
endmodule